// File: doc/BRIEF.md
# Channel-Gain Scan Sequencer

This block keeps a list of up to 256 conversion entries. Each entry pairs an analog input channel with a range code. One entry is applied per A/D conversion. The current entry drives the multiplexer select and the range/gain code of the converter front end from registers. Each single-cycle conversion strobe moves the block to the next entry. After the last entry of the list it returns to entry 0, so a scan repeats without help from the host.

The host programs the block through a byte-wide register port with three registers:

- An index register picks the entry to be written.
- A data register writes the entry byte at that index.
- A last-index register sets where the scan wraps.

A list of two or more entries must keep even channels at even positions and odd channels at odd positions, and its length must be even. The block watches the bytes the host writes and raises `list_error` when the list breaks either rule. A one-entry list is always legal and repeats its entry on every conversion. Pulsing `arm` starts a new acquisition at entry 0.

Top module: `scanq_top`

## Requirements
- R1: After a synchronous reset, mux_sel, range_code, unipolar and list_error are all 0. The scan position is entry 0, all entries hold 0, and the last-index register holds 0.
- R2: A write to offset 6 loads the entry index. A write to offset 7 stores the byte at that index: bits 2:0 are the channel, bits 7:4 the range code, and bit 3 is ignored.
- R3: A cycle with arm high sets the scan position to 0. mux_sel and range_code show entry 0 from the next cycle on.
- R4: A conversion strobe moves the scan position to the next entry, and the outputs show that entry from the next cycle on. With neither a strobe nor arm, the outputs hold their values.
- R5: Offset 4 holds the index of the last entry (list length minus 1). A strobe taken while the scan position equals that index returns the position to entry 0.
- R6: With last index 0 (one-entry list), every strobe applies entry 0 again, and list_error stays 0 whatever the channel.
- R7: unipolar equals bit 6 of the applied entry byte, which is bit 2 of its range code.
- R8: list_error is high when the last index is nonzero and either the last index is even (odd length) or the index-parity flag is set. The flag is set by a data write whose channel bit 0 differs from bit 0 of the entry index.
- R9: A write of 0 to offset 6 clears the index-parity flag and sets the scan position to 0 without changing the outputs. A strobe in the same cycle does not advance the position.
- R10: When arm and a strobe arrive in the same cycle, arm wins. Host writes to offsets 0, 1, 2, 3 and 5 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 3 | Host register offset |
| host_wdata | input | 8 | Host write byte |
| arm | input | 1 | Start of a new acquisition (one cycle) |
| conv_strobe | input | 1 | Conversion strobe (one cycle) |
| mux_sel | output | 3 | Channel select to the analog mux |
| range_code | output | 4 | Range/gain code to the front end |
| unipolar | output | 1 | Applied range is unipolar |
| list_error | output | 1 | Scan list breaks the pairing rules |

## Verification
The scan is tried under four stimulus patterns:

- A legal four-entry list, stepped past its wrap point, separates correct wrapping from running off the end of the list.
- A one-entry list with an odd channel shows that the repeat case is exempt from the pairing rule.
- A misplaced channel, then an odd length, then a rewind write exercise the error flag's set and clear paths separately.
- Collisions between arm, rewind writes and strobes in one cycle, writes to unused offsets, and a long run of random strobes and arms check priority and isolation against the reference model on every clock.

// File: rtl/scanq_pkg.sv
package scanq_pkg;

    typedef struct packed {
        logic [3:0] rng;
        logic [2:0] chan;
    } q_entry_t;

    typedef enum logic [1:0] {
        SEQ_HOLD,
        SEQ_STEP,
        SEQ_REWIND,
        SEQ_ARM
    } seq_op_t;

    function automatic q_entry_t unpack_entry(input logic [7:0] b);
        q_entry_t e;
        e.rng  = b[7:4];
        e.chan = b[2:0];
        return e;
    endfunction

    function automatic logic parity_clash(input logic [2:0] chan, input logic idx_lsb);
        return chan[0] ^ idx_lsb;
    endfunction

endpackage

// File: rtl/scanq_store.sv
module scanq_store
    import scanq_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  q_entry_t         wdata,
    input  logic [IDX_W-1:0] raddr,
    output q_entry_t         rdata
);

    q_entry_t mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/scanq_rules.sv
module scanq_rules
    import scanq_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             chk,
    input  logic [2:0]       chan,
    input  logic             idx_lsb,
    input  logic [IDX_W-1:0] len_last,
    output logic             par_bad,
    output logic             list_error
);

    logic par_bad_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            par_bad_q <= 1'b0;
        else if (chk && parity_clash(chan, idx_lsb))
            par_bad_q <= 1'b1;
    end

    assign par_bad    = par_bad_q;
    assign list_error = (len_last != '0) && (par_bad_q || !len_last[0]);

endmodule

// File: rtl/scanq_seq.sv
module scanq_seq
    import scanq_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  seq_op_t          op,
    input  logic [IDX_W-1:0] len_last,
    input  q_entry_t         rd_entry,
    output logic [IDX_W-1:0] rd_idx,
    output logic [IDX_W-1:0] ptr,
    output q_entry_t         cur
);

    logic [IDX_W-1:0] ptr_q, nxt;
    q_entry_t         cur_q;

    assign nxt    = (ptr_q == len_last) ? '0 : ptr_q + 1'b1;
    assign rd_idx = (op == SEQ_ARM) ? '0 : nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
            cur_q <= '0;
        end else begin
            unique case (op)
                SEQ_ARM: begin
                    ptr_q <= '0;
                    cur_q <= rd_entry;
                end
                SEQ_REWIND: ptr_q <= '0;
                SEQ_STEP: begin
                    ptr_q <= nxt;
                    cur_q <= rd_entry;
                end
                default: ;
            endcase
        end
    end

    assign ptr = ptr_q;
    assign cur = cur_q;

endmodule

// File: rtl/scanq_top.sv
module scanq_top
    import scanq_pkg::*;
#(
    parameter int             DEPTH    = 256,
    parameter int             AW       = 3,
    parameter logic [AW-1:0]  OFF_LEN  = 3'd4,
    parameter logic [AW-1:0]  OFF_IDX  = 3'd6,
    parameter logic [AW-1:0]  OFF_DATA = 3'd7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_wr,
    input  logic [AW-1:0] host_addr,
    input  logic [7:0]    host_wdata,
    input  logic          arm,
    input  logic          conv_strobe,
    output logic [2:0]    mux_sel,
    output logic [3:0]    range_code,
    output logic          unipolar,
    output logic          list_error
);

    localparam int IDX_W = $clog2(DEPTH);

    logic             wr_len, wr_idx, wr_data, wr_rewind;
    logic [IDX_W-1:0] idx_q, len_last_q, rd_idx, ptr_q;
    logic             par_bad;
    q_entry_t         rd_entry, cur;
    seq_op_t          op;

    assign wr_len    = host_wr && (host_addr == OFF_LEN);
    assign wr_idx    = host_wr && (host_addr == OFF_IDX);
    assign wr_data   = host_wr && (host_addr == OFF_DATA);
    assign wr_rewind = wr_idx && (host_wdata[IDX_W-1:0] == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q      <= '0;
            len_last_q <= '0;
        end else begin
            if (wr_idx) idx_q      <= host_wdata[IDX_W-1:0];
            if (wr_len) len_last_q <= host_wdata[IDX_W-1:0];
        end
    end

    always_comb begin
        if (arm)              op = SEQ_ARM;
        else if (wr_rewind)   op = SEQ_REWIND;
        else if (conv_strobe) op = SEQ_STEP;
        else                  op = SEQ_HOLD;
    end

    scanq_store #(.DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_data),
        .waddr (idx_q),
        .wdata (unpack_entry(host_wdata)),
        .raddr (rd_idx),
        .rdata (rd_entry)
    );

    scanq_rules #(.IDX_W(IDX_W)) u_rules (
        .clk        (clk),
        .rst        (rst),
        .clr        (wr_rewind),
        .chk        (wr_data),
        .chan       (host_wdata[2:0]),
        .idx_lsb    (idx_q[0]),
        .len_last   (len_last_q),
        .par_bad    (par_bad),
        .list_error (list_error)
    );

    scanq_seq #(.IDX_W(IDX_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .len_last (len_last_q),
        .rd_entry (rd_entry),
        .rd_idx   (rd_idx),
        .ptr      (ptr_q),
        .cur      (cur)
    );

    assign mux_sel    = cur.chan;
    assign range_code = cur.rng;
    assign unipolar   = cur.rng[2];

endmodule

// File: rtl/scanq_checker.sv
module scanq_checker #(
    parameter int            IDX_W   = 8,
    parameter int            AW      = 3,
    parameter logic [AW-1:0] OFF_IDX = 3'd6
) (
    input logic             clk,
    input logic             rst,
    input logic             host_wr,
    input logic [AW-1:0]    host_addr,
    input logic [7:0]       host_wdata,
    input logic             arm,
    input logic             conv_strobe,
    input logic [2:0]       mux_sel,
    input logic [3:0]       range_code,
    input logic             list_error,
    input logic [IDX_W-1:0] ptr,
    input logic [IDX_W-1:0] len_last,
    input logic             par_bad
);

    logic rewind;
    assign rewind = host_wr && (host_addr == OFF_IDX) && (host_wdata[IDX_W-1:0] == '0);

    // R3: arm sends the scan back to entry 0
    a_r3_arm_zero: assert property (@(posedge clk) disable iff (rst)
        arm |=> (ptr == '0));

    // R4: no strobe and no arm keeps the applied entry
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (!arm && !conv_strobe) |=> ($stable(mux_sel) && $stable(range_code)));

    // R5: a strobe at the last index wraps to entry 0
    a_r5_wrap: assert property (@(posedge clk) disable iff (rst)
        (conv_strobe && !arm && !rewind && (ptr == len_last)) |=> (ptr == '0));

    // R6: a one-entry list is never flagged
    a_r6_single_ok: assert property (@(posedge clk) disable iff (rst)
        (len_last == '0) |-> !list_error);

    // R8: an odd length above one is always flagged
    a_r8_odd_len: assert property (@(posedge clk) disable iff (rst)
        ((len_last != '0) && !len_last[0]) |-> list_error);

    // R9: a rewind write clears the parity flag and the position
    a_r9_rewind: assert property (@(posedge clk) disable iff (rst)
        (rewind && !arm) |=> (!par_bad && (ptr == '0)));

endmodule

bind scanq_top scanq_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .host_wr     (host_wr),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .arm         (arm),
    .conv_strobe (conv_strobe),
    .mux_sel     (mux_sel),
    .range_code  (range_code),
    .list_error  (list_error),
    .ptr         (ptr_q),
    .len_last    (len_last_q),
    .par_bad     (par_bad)
);

// File: tb/tb_scanq_top.sv
`timescale 1ns/1ps
module tb_scanq_top;

    logic       clk = 0;
    logic       rst = 1;
    logic       host_wr = 0;
    logic [2:0] host_addr = 0;
    logic [7:0] host_wdata = 0;
    logic       arm = 0;
    logic       conv_strobe = 0;
    logic [2:0] mux_sel;
    logic [3:0] range_code;
    logic       unipolar;
    logic       list_error;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    bit running = 0;
    string tag = "R4";

    always #4 clk = ~clk;

    scanq_top dut (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .arm(arm), .conv_strobe(conv_strobe),
        .mux_sel(mux_sel), .range_code(range_code), .unipolar(unipolar),
        .list_error(list_error)
    );

    // behavioural reference model
    int m_ent [256];
    int m_idx, m_last, m_ptr, m_cur;
    bit m_bad;

    always @(posedge clk) begin
        int nx;
        if (rst) begin
            foreach (m_ent[i]) m_ent[i] = 0;
            m_idx = 0; m_last = 0; m_ptr = 0; m_cur = 0; m_bad = 0;
        end else begin
            nx = (m_ptr == m_last) ? 0 : (m_ptr + 1) % 256;
            if (arm) begin
                m_ptr = 0; m_cur = m_ent[0];
            end else if (host_wr && host_addr == 6 && host_wdata == 0) begin
                m_ptr = 0;
            end else if (conv_strobe) begin
                m_cur = m_ent[nx]; m_ptr = nx;
            end
            if (host_wr) begin
                case (host_addr)
                    3'd4: m_last = host_wdata;
                    3'd6: begin
                        m_idx = host_wdata;
                        if (host_wdata == 0) m_bad = 0;
                    end
                    3'd7: begin
                        m_ent[m_idx] = host_wdata;
                        if (host_wdata[0] != m_idx[0]) m_bad = 1;
                    end
                    default: ;
                endcase
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (running && !rst) begin
            check({tag, " mux_sel"}, mux_sel, m_cur & 7);
            check({tag, " range_code"}, range_code, (m_cur >> 4) & 15);
            check("R7 unipolar", unipolar, (m_cur >> 6) & 1);
            check("R8 list_error", list_error,
                  ((m_last != 0) && (m_bad || (m_last % 2 == 0))) ? 1 : 0);
        end
    end

    task automatic wr(input int a, input int d);
        host_wr = 1; host_addr = a[2:0]; host_wdata = d[7:0];
        @(negedge clk);
        host_wr = 0;
    endtask

    task automatic step();
        conv_strobe = 1;
        @(negedge clk);
        conv_strobe = 0;
    endtask

    task automatic do_arm();
        arm = 1;
        @(negedge clk);
        arm = 0;
    endtask

    task automatic load_entry(input int i, input int b);
        wr(6, i);
        wr(7, b);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1 mux_sel", mux_sel, 0);
        check("R1 range_code", range_code, 0);
        check("R1 unipolar", unipolar, 0);
        check("R1 list_error", list_error, 0);
        running = 1;

        // R2: legal four-entry list, bit 3 of entry 2 set and ignored
        tag = "R2";
        load_entry(0, 8'h00);
        load_entry(1, 8'h53);
        load_entry(2, 8'h8A);
        load_entry(3, 8'h45);
        wr(4, 3);
        check("R8 legal list", list_error, 0);

        tag = "R3";
        do_arm();
        check("R3 sel after arm", mux_sel, 0);
        tag = "R4";
        step();
        check("R4 sel", mux_sel, 3); check("R4 rng", range_code, 5); check("R7 uni", unipolar, 1);
        step();
        check("R2 bit3 ignored", mux_sel, 2); check("R2 rng", range_code, 8);
        step();
        check("R4 sel e3", mux_sel, 5); check("R4 rng e3", range_code, 4);
        tag = "R5";
        step();
        check("R5 wrap", mux_sel, 0);
        repeat (2) @(negedge clk);
        check("R4 hold", mux_sel, 0);
        for (int k = 0; k < 5; k++) step();

        // R6: one-entry list with odd channel
        tag = "R6";
        load_entry(0, 8'h61);
        wr(4, 0);
        do_arm();
        step(); step();
        check("R6 sel", mux_sel, 1); check("R6 rng", range_code, 6);
        check("R7 unipolar", unipolar, 1); check("R6 no error", list_error, 0);

        // R8: odd length and misplaced channel
        tag = "R8";
        wr(4, 2);
        check("R8 odd length", list_error, 1);
        wr(4, 3);
        check("R8 parity flag", list_error, 1);
        load_entry(0, 8'h00);
        check("R9 cleared", list_error, 0);
        load_entry(2, 8'h03);
        check("R8 ch3 at idx2", list_error, 1);
        wr(6, 0);
        check("R9 clear by rewind", list_error, 0);

        // R9: rewind together with a strobe
        tag = "R9";
        do_arm();
        step(); step();
        check("R9 pre sel", mux_sel, 3); check("R9 pre rng", range_code, 0);
        conv_strobe = 1;
        wr(6, 0);
        conv_strobe = 0;
        check("R9 outputs kept", range_code, 0);
        step();
        check("R9 restart at e1", range_code, 5);

        // R10: arm beats strobe
        tag = "R10";
        arm = 1; conv_strobe = 1;
        @(negedge clk);
        arm = 0; conv_strobe = 0;
        check("R10 arm wins", range_code, 0);
        step();
        check("R10 next e1", range_code, 5);

        // R10: unused offsets ignored
        wr(0, 8'hFF); wr(1, 8'hFF); wr(2, 8'hFF); wr(3, 8'hFF); wr(5, 8'hFF);
        check("R10 outputs kept", range_code, 5);
        check("R10 error kept", list_error, 0);
        step(); step();
        check("R10 e3 intact", mux_sel, 5);
        step();
        check("R10 length intact", mux_sel, 0);

        // random strobes and arms against the model
        tag = "R4";
        for (int k = 0; k < 400; k++) begin
            conv_strobe = ($urandom_range(0, 2) != 0);
            arm = ($urandom_range(0, 40) == 0);
            @(negedge clk);
        end
        conv_strobe = 0; arm = 0;
        @(negedge clk);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule